// File: doc/BRIEF.md
# Two-Dimensional Chained Block Mover

This engine copies rectangular regions of words inside a shared main memory, one rectangle per descriptor. A rectangle is a count of words per line, a count of lines, and a separate line pitch for the source and for the destination. Software does not start each copy. It writes a linked list of descriptors into a small local data RAM, gives the engine the address of the first one, and pulses a start pin. The engine then reads each descriptor straight from that RAM, runs it, and follows the link to the next descriptor until it reaches the one marked final.

On the bus side, the engine issues one request at a time over a valid/ready channel. A request stays valid, with its address, direction and write data held steady, until ready is seen high at a clock edge. A read is answered by a one-cycle response pulse, which the engine always accepts, and the response may arrive any number of cycles later. Writes are posted and get no response. Software is told only that the whole chain is finished. It gets a one-cycle interrupt pulse and a sticky status flag, which it clears by writing 1.

Top module: `dma2d_ctrl`

## Requirements
- R1: After reset, busy, status, interrupt, bus request valid and data RAM enable are all 0.
- R2: A descriptor is six consecutive data RAM words at word address p to p+5. The words are: p+0 source base, p+1 destination base, p+2 words per line in bits 15:0 and line count in bits 31:16, p+3 source pitch, p+4 destination pitch, p+5 next-descriptor address in its low bits with the final flag in bit 31. The engine reads them in ascending order, and the RAM returns data one cycle after the enable.
- R3: Within a line, source and destination addresses each advance by one. After the last word of a line, each returns to its own line start plus its own pitch.
- R4: Each word is read from its source address and the returned data is written to its destination address, going through the columns of a line in order and then through the lines in order.
- R5: While request valid is high and ready is low, the request's valid, address, direction and write data hold. Each word is read exactly once and written exactly once.
- R6: When a completed descriptor is not marked final, the engine fetches the descriptor at its next-descriptor address, without any software action.
- R7: When the final descriptor completes, the interrupt pin is high for exactly one cycle, status becomes 1 and busy drops. Nothing of this happens for descriptors that are not final.
- R8: Status stays 1 until the clear pin is 1 at a clock edge. If completion and clear fall on the same edge, status is 1.
- R9: A descriptor with zero words per line or zero lines makes no bus request, and the chain goes on, or ends if that descriptor is final.
- R10: The start pin is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| desc_ptr_i | input | RAM_AW | Data RAM word address of the first descriptor |
| sts_clr_i | input | 1 | Write-1-to-clear of the status flag |
| busy_o | output | 1 | Chain in progress |
| sts_done_o | output | 1 | Sticky chain-finished flag |
| irq_done_o | output | 1 | One-cycle chain-finished pulse |
| dram_en_o | output | 1 | Data RAM read enable |
| dram_addr_o | output | RAM_AW | Data RAM read word address |
| dram_rdata_i | input | 32 | Data RAM read data, one cycle after enable |
| mem_req_valid_o | output | 1 | Bus request valid |
| mem_req_ready_i | input | 1 | Bus request accepted |
| mem_req_we_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | 32 | Bus word address |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read response pulse |
| mem_rsp_data_i | input | 32 | Read response data |

## Verification
The interesting collision is between the engine setting the status flag when a chain ends and software clearing it. The bench holds the clear pin at 1 for the whole of a run. This places a clear on the same edge as completion. In the cycle where the interrupt is seen, status must read 1. In the next cycle, with clear still high, it must read 0. A second overlap, a start pulse arriving while a chain runs, is judged by checking that the memory region the second descriptor would have written is untouched and that only six descriptor words were read.

// File: rtl/dma2d_pkg.sv
`timescale 1ns/1ps
package dma2d_pkg;
  parameter int unsigned AW = 32;
  parameter int unsigned CW = 16;
  parameter int unsigned DESC_WORDS = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_RD, ST_WAIT, ST_WR, ST_NEXT
  } st_e;

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [AW-1:0] sstride;
    logic [AW-1:0] dstride;
    logic [CW-1:0] width;
    logic [CW-1:0] height;
  } rect_t;
endpackage

// File: rtl/dma2d_desc_fetch.sv
`timescale 1ns/1ps
module dma2d_desc_fetch
  import dma2d_pkg::*;
#(
  parameter int unsigned RAM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RAM_AW-1:0] ptr_i,
  output logic              en_o,
  output logic [RAM_AW-1:0] addr_o,
  input  logic [AW-1:0]     rdata_i,
  output logic              done_o,
  output rect_t             rect_o,
  output logic [RAM_AW-1:0] next_o,
  output logic              last_o
);
  localparam int unsigned IW = $clog2(DESC_WORDS);
  localparam int unsigned NBODY = DESC_WORDS - 1;

  logic              active_q;
  logic [IW-1:0]     cnt_q;
  logic [RAM_AW-1:0] base_q;
  logic              rv_q;
  logic [IW-1:0]     ridx_q;
  logic              done_q;
  logic [AW-1:0]     words_q [NBODY];
  logic [RAM_AW-1:0] next_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      rv_q     <= 1'b0;
      ridx_q   <= '0;
      done_q   <= 1'b0;
      next_q   <= '0;
      last_q   <= 1'b0;
      for (int i = 0; i < int'(NBODY); i++) words_q[i] <= '0;
    end else begin
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        base_q   <= ptr_i;
      end else if (active_q) begin
        cnt_q <= cnt_q + IW'(1);
        if (cnt_q == IW'(DESC_WORDS - 1)) active_q <= 1'b0;
      end
      rv_q   <= active_q;
      ridx_q <= cnt_q;
      if (rv_q) begin
        if (ridx_q == IW'(DESC_WORDS - 1)) begin
          next_q <= rdata_i[RAM_AW-1:0];
          last_q <= rdata_i[AW-1];
        end else begin
          words_q[ridx_q] <= rdata_i;
        end
      end
      done_q <= rv_q && (ridx_q == IW'(DESC_WORDS - 1));
    end
  end

  assign en_o   = active_q;
  assign addr_o = base_q + RAM_AW'(cnt_q);
  assign done_o = done_q;
  assign next_o = next_q;
  assign last_o = last_q;

  assign rect_o.src     = words_q[0];
  assign rect_o.dst     = words_q[1];
  assign rect_o.width   = words_q[2][CW-1:0];
  assign rect_o.height  = words_q[2][2*CW-1:CW];
  assign rect_o.sstride = words_q[3];
  assign rect_o.dstride = words_q[4];

  // R2
  fetch_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && $past(en_o)) |-> (addr_o == $past(addr_o) + RAM_AW'(1)));
endmodule

// File: rtl/dma2d_addr_gen.sv
`timescale 1ns/1ps
module dma2d_addr_gen
  import dma2d_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  rect_t         rect_i,
  input  logic          step_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          last_o
);
  logic [CW-1:0] col_q, row_q, width_q, height_q;
  logic [AW-1:0] sline_q, dline_q, src_q, dst_q, sstr_q, dstr_q;
  logic          eol;

  assign eol    = (col_q == width_q - CW'(1));
  assign last_o = eol && (row_q == height_q - CW'(1));
  assign src_o  = src_q;
  assign dst_o  = dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0; row_q <= '0; width_q <= '0; height_q <= '0;
      sline_q <= '0; dline_q <= '0; src_q <= '0; dst_q <= '0;
      sstr_q <= '0; dstr_q <= '0;
    end else if (load_i) begin
      col_q    <= '0;
      row_q    <= '0;
      width_q  <= rect_i.width;
      height_q <= rect_i.height;
      sline_q  <= rect_i.src;
      dline_q  <= rect_i.dst;
      src_q    <= rect_i.src;
      dst_q    <= rect_i.dst;
      sstr_q   <= rect_i.sstride;
      dstr_q   <= rect_i.dstride;
    end else if (step_i) begin
      if (eol) begin
        col_q   <= '0;
        row_q   <= row_q + CW'(1);
        sline_q <= sline_q + sstr_q;
        dline_q <= dline_q + dstr_q;
        src_q   <= sline_q + sstr_q;
        dst_q   <= dline_q + dstr_q;
      end else begin
        col_q <= col_q + CW'(1);
        src_q <= src_q + AW'(1);
        dst_q <= dst_q + AW'(1);
      end
    end
  end

  // R3
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !eol) |=>
      (src_o == $past(src_o) + AW'(1)) && (dst_o == $past(dst_o) + AW'(1)));
endmodule

// File: rtl/dma2d_ctrl.sv
`timescale 1ns/1ps
module dma2d_ctrl
  import dma2d_pkg::*;
#(
  parameter int unsigned RAM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RAM_AW-1:0] desc_ptr_i,
  input  logic              sts_clr_i,
  output logic              busy_o,
  output logic              sts_done_o,
  output logic              irq_done_o,
  output logic              dram_en_o,
  output logic [RAM_AW-1:0] dram_addr_o,
  input  logic [31:0]       dram_rdata_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic [31:0]       mem_req_addr_o,
  output logic [31:0]       mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [31:0]       mem_rsp_data_i
);
  st_e               state_q, state_d;
  logic [AW-1:0]     rdata_q;
  logic              irq_q, sts_q;
  logic              f_start, f_done, f_last;
  logic [RAM_AW-1:0] f_ptr, f_next;
  rect_t             rect;
  logic              ag_load, ag_step, ag_last, zero_size, fin;
  logic [AW-1:0]     ag_src, ag_dst;

  assign zero_size = (rect.width == '0) || (rect.height == '0);
  assign fin       = (state_q == ST_NEXT) && f_last;
  assign f_start   = ((state_q == ST_IDLE) && start_i) ||
                     ((state_q == ST_NEXT) && !f_last);
  assign f_ptr     = (state_q == ST_IDLE) ? desc_ptr_i : f_next;
  assign ag_load   = (state_q == ST_FETCH) && f_done;
  assign ag_step   = (state_q == ST_WR) && mem_req_ready_i;

  dma2d_desc_fetch #(.RAM_AW(RAM_AW)) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(f_start), .ptr_i(f_ptr),
    .en_o(dram_en_o), .addr_o(dram_addr_o), .rdata_i(dram_rdata_i),
    .done_o(f_done), .rect_o(rect), .next_o(f_next), .last_o(f_last)
  );

  dma2d_addr_gen u_agen (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ag_load), .rect_i(rect),
    .step_i(ag_step), .src_o(ag_src), .dst_o(ag_dst), .last_o(ag_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_FETCH;
      ST_FETCH: if (f_done) state_d = zero_size ? ST_NEXT : ST_RD;
      ST_RD:    if (mem_req_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid_i) state_d = ST_WR;
      ST_WR:    if (mem_req_ready_i) state_d = ag_last ? ST_NEXT : ST_RD;
      ST_NEXT:  state_d = f_last ? ST_IDLE : ST_FETCH;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
      irq_q   <= 1'b0;
      sts_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAIT && mem_rsp_valid_i) rdata_q <= mem_rsp_data_i;
      irq_q <= fin;
      if (fin)            sts_q <= 1'b1;
      else if (sts_clr_i) sts_q <= 1'b0;
    end
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign sts_done_o      = sts_q;
  assign irq_done_o      = irq_q;
  assign mem_req_valid_o = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_req_we_o    = (state_q == ST_WR);
  assign mem_req_addr_o  = (state_q == ST_WR) ? ag_dst : ag_src;
  assign mem_req_wdata_o = rdata_q;

  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) &&
       $stable(mem_req_we_o) && $stable(mem_req_wdata_o)));
  // R7
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |=> !irq_done_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_valid_o && !dram_en_o));
  // R4
  wr_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_valid_o && mem_req_we_o) |-> $past(mem_rsp_valid_i));
endmodule

// File: tb/dma2d_ctrl_bench.sv
`timescale 1ns/1ps
module dma2d_ctrl_bench;
  localparam int RAW = 8;
  localparam int NV = 5;
  localparam int V_SRC [NV] = '{0, 16, 40, 100, 200};
  localparam int V_DST [NV] = '{512, 600, 700, 800, 900};
  localparam int V_W   [NV] = '{4, 1, 6, 3, 2};
  localparam int V_H   [NV] = '{3, 5, 1, 4, 2};
  localparam int V_SS  [NV] = '{8, 3, 0, 10, 2};
  localparam int V_DS  [NV] = '{4, 2, 0, 5, 7};
  localparam int V_ST  [NV] = '{0, 1, 1, 1, 0};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_ni, start_i, sts_clr_i;
  logic [RAW-1:0] desc_ptr_i;
  logic           busy_o, sts_done_o, irq_done_o, dram_en_o;
  logic [RAW-1:0] dram_addr_o;
  logic [31:0]    dram_rdata_i;
  logic           mem_req_valid_o, mem_req_ready_i, mem_req_we_o;
  logic [31:0]    mem_req_addr_o, mem_req_wdata_o;
  logic           mem_rsp_valid_i;
  logic [31:0]    mem_rsp_data_i;

  dma2d_ctrl #(.RAM_AW(RAW)) u_dma2d_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .desc_ptr_i(desc_ptr_i),
    .sts_clr_i(sts_clr_i), .busy_o(busy_o), .sts_done_o(sts_done_o),
    .irq_done_o(irq_done_o), .dram_en_o(dram_en_o), .dram_addr_o(dram_addr_o),
    .dram_rdata_i(dram_rdata_i), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_req_we_o(mem_req_we_o),
    .mem_req_addr_o(mem_req_addr_o), .mem_req_wdata_o(mem_req_wdata_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i)
  );

  logic [31:0] mem  [1024];
  logic [31:0] dram [256];
  logic        rsp_pend, stall_en;
  int          rsp_dly;
  logic [31:0] rsp_dat, dram_pend;
  logic [7:0]  lfsr;
  int n_rd, n_wr, n_irq, n_fetch, first_faddr;
  int ntests, nfail;

  function automatic logic [31:0] pat(int i);
    return 32'hC0DE_0000 + 32'(i * 7);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_rd = 0; n_wr = 0; n_irq = 0; n_fetch = 0; first_faddr = -1;
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
  endtask

  task automatic put_desc(int p, int src, int dst, int w, int h, int ss, int ds,
                          int nxt, bit last);
    dram[p]   = 32'(src);
    dram[p+1] = 32'(dst);
    dram[p+2] = {16'(h), 16'(w)};
    dram[p+3] = 32'(ss);
    dram[p+4] = 32'(ds);
    dram[p+5] = {last, 31'(nxt)};
  endtask

  task automatic model_step();
    mem_rsp_valid_i = 1'b0;
    if (rsp_pend) begin
      if (rsp_dly == 0) begin
        mem_rsp_valid_i = 1'b1; mem_rsp_data_i = rsp_dat; rsp_pend = 1'b0;
      end else rsp_dly--;
    end
    dram_rdata_i = dram_pend;
    if (dram_en_o) begin
      dram_pend = dram[dram_addr_o];
      n_fetch++;
      if (first_faddr < 0) first_faddr = int'(dram_addr_o);
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready_i = stall_en ? lfsr[0] : 1'b1;
    if (mem_req_valid_o && mem_req_ready_i) begin
      if (mem_req_we_o) begin
        mem[mem_req_addr_o[9:0]] = mem_req_wdata_o; n_wr++;
      end else begin
        rsp_pend = 1'b1; rsp_dly = 1; rsp_dat = mem[mem_req_addr_o[9:0]]; n_rd++;
      end
    end
    if (irq_done_o) n_irq++;
  endtask

  initial begin
    rsp_pend = 0; rsp_dly = 0; rsp_dat = '0; dram_pend = '0; lfsr = 8'h5A;
    stall_en = 0; mem_req_ready_i = 1; mem_rsp_valid_i = 0; mem_rsp_data_i = '0;
    dram_rdata_i = '0;
    forever begin
      @(negedge clk);
      model_step();
    end
  end

  task automatic wait_done(int maxc);
    int c = 0;
    while (!irq_done_o && c < maxc) begin @(negedge clk); c++; end
  endtask

  task automatic run(int p);
    clear_counts();
    @(negedge clk); start_i = 1; desc_ptr_i = RAW'(p);
    @(negedge clk); start_i = 0;
    wait_done(20000);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_rect(string req, int src, int dst, int w, int h, int ss, int ds);
    int bad = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        if (mem[dst + r*ds + c] != pat(src + r*ss + c)) bad++;
    chk(bad == 0, req, "rectangle word mismatches", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    ntests = 0; nfail = 0; clear_counts();
    rst_ni = 0; start_i = 0; sts_clr_i = 0; desc_ptr_i = '0;
    for (int i = 0; i < 256; i++) dram[i] = '0;
    fill_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !sts_done_o && !irq_done_o, "R1", "busy/status/irq in reset",
        int'({busy_o, sts_done_o, irq_done_o}), 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk(!mem_req_valid_o && !dram_en_o, "R1", "request/enable after reset",
        int'({mem_req_valid_o, dram_en_o}), 0);

    // vector table: single-descriptor chains
    for (int v = 0; v < NV; v++) begin
      fill_mem();
      stall_en = V_ST[v][0];
      put_desc(0, V_SRC[v], V_DST[v], V_W[v], V_H[v], V_SS[v], V_DS[v], 0, 1'b1);
      run(0);
      check_rect("R3/R4", V_SRC[v], V_DST[v], V_W[v], V_H[v], V_SS[v], V_DS[v]);
      chk(n_wr == V_W[v]*V_H[v], "R5", "write count", n_wr, V_W[v]*V_H[v]);
      chk(n_rd == V_W[v]*V_H[v], "R5", "read count", n_rd, V_W[v]*V_H[v]);
      chk(n_irq == 1, "R7", "interrupt cycles", n_irq, 1);
      chk(sts_done_o && !busy_o, "R7", "status set and idle",
          int'({sts_done_o, busy_o}), 2);
      chk(first_faddr == 0 && n_fetch == 6, "R2", "descriptor fetch words",
          n_fetch, 6);
      if (V_DS[v] > V_W[v])
        chk(mem[V_DST[v] + V_W[v]] == pat(V_DST[v] + V_W[v]), "R3",
            "pitch gap untouched", int'(mem[V_DST[v] + V_W[v]]),
            int'(pat(V_DST[v] + V_W[v])));
      // R8 status stays until cleared
      repeat (3) @(negedge clk);
      chk(sts_done_o, "R8", "status held", int'(sts_done_o), 1);
      sts_clr_i = 1; @(negedge clk); sts_clr_i = 0;
      chk(!sts_done_o, "R8", "status cleared", int'(sts_done_o), 0);
    end

    // R6 and R9: chain of three, middle one empty, out of address order
    fill_mem(); stall_en = 1;
    put_desc(20, 300, 400, 3, 2, 5, 3, 40, 1'b0);
    put_desc(40, 0, 1000, 0, 5, 1, 1, 10, 1'b0);
    put_desc(10, 320, 420, 2, 3, 4, 2, 0, 1'b1);
    run(20);
    check_rect("R6", 300, 400, 3, 2, 5, 3);
    check_rect("R6", 320, 420, 2, 3, 4, 2);
    chk(n_wr == 12, "R9", "writes across chain", n_wr, 12);
    chk(n_fetch == 18 && first_faddr == 20, "R6", "descriptor words fetched",
        n_fetch, 18);
    chk(n_irq == 1, "R7", "one interrupt per chain", n_irq, 1);
    sts_clr_i = 1; @(negedge clk); sts_clr_i = 0;

    // R9 zero-height final descriptor
    put_desc(50, 0, 1000, 3, 0, 1, 1, 0, 1'b1);
    run(50);
    chk(n_rd == 0 && n_wr == 0, "R9", "bus traffic for empty rectangle",
        n_rd + n_wr, 0);
    chk(n_irq == 1 && sts_done_o, "R9", "empty final still completes", n_irq, 1);

    // R8 completion and clear on the same edge
    fill_mem(); stall_en = 0;
    put_desc(0, 0, 512, 2, 2, 2, 2, 0, 1'b1);
    sts_clr_i = 1;
    @(negedge clk);
    chk(!sts_done_o, "R8", "status cleared before run", int'(sts_done_o), 0);
    @(negedge clk); start_i = 1; desc_ptr_i = '0;
    @(negedge clk); start_i = 0;
    wait_done(20000);
    chk(sts_done_o, "R8", "set wins over clear", int'(sts_done_o), 1);
    @(negedge clk);
    chk(!sts_done_o, "R8", "clear next cycle", int'(sts_done_o), 0);
    sts_clr_i = 0;
    repeat (4) @(negedge clk);

    // R10 start while busy is ignored
    fill_mem(); stall_en = 1;
    put_desc(0, 0, 512, 4, 3, 8, 4, 0, 1'b1);
    put_desc(30, 60, 950, 4, 1, 0, 0, 0, 1'b1);
    clear_counts();
    @(negedge clk); start_i = 1; desc_ptr_i = '0;
    @(negedge clk); start_i = 0;
    repeat (10) @(negedge clk);
    start_i = 1; desc_ptr_i = RAW'(30);
    @(negedge clk); start_i = 0;
    wait_done(20000);
    repeat (6) @(negedge clk);
    chk(mem[950] == pat(950), "R10", "second region untouched",
        int'(mem[950]), int'(pat(950)));
    chk(n_fetch == 6 && n_irq == 1, "R10", "only one descriptor run", n_fetch, 6);
    chk(!busy_o, "R10", "idle after chain", int'(busy_o), 0);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule